// File: doc/BRIEF.md
# Wake-up Event Control and Status

This block holds the wake-up policy and the wake-up status of a network controller's power-management logic. It watches the link-status line. It finds transitions from down to up and from up to down, and each direction has its own enable. It also takes single-cycle indications from a wake-up frame matcher and a magic-packet detector. Each enabled source can raise a sticky power-management event. That event drives an output pin until software clears it.

Software reaches the block through a two-address register port. Address 0 is a control word. It holds the direction enables, the source enables, five per-pattern match enables and a CRC seed select. The pattern enables and the seed value go out to the frame matcher. Address 1 is a status word. Its bits are cleared by writing one to them. The wake-up status bits are reset only by the power-up reset, so they keep their values through a hardware or software reset. The control word and the link-change flag are cleared by either reset.

Top module: `wake_evt_top`

## Requirements
- R1: With control bit 1 (link-up detect) set, a low-to-high change of `linkUp` sets status bit 2 (`lscFlag`). With bit 1 clear, the same change leaves status bit 2 at zero.
- R2: With control bit 0 (link-down detect) set, a high-to-low change of `linkUp` sets status bit 2. With bit 0 clear, the same change leaves status bit 2 at zero.
- R3: A `frameHit` pulse always sets status bit 0. It also sets status bit 3 (`pmeOut`) only when control bit 2 is set.
- R4: A `magicHit` pulse always sets status bit 1. It also sets status bit 3 only when control bit 3 is set. Control bit 2 does not enable this path.
- R5: A link change in a direction whose detect bit is set also sets status bit 3 when control bit 4 is set. A change in a direction that is not enabled does not set status bit 3.
- R6: A write to address 1 clears exactly the status bits written as one. Status bits written as zero keep their value.
- R7: `sysRstN` clears the control word and status bit 2. It leaves status bits 0, 1 and 3 unchanged. `porRstN` clears everything.
- R8: When a status set event and a write of one to that bit arrive in the same cycle, the bit ends set.
- R9: `pmeOut` stays high until software writes one to status bit 3.
- R10: `patEnable` equals control bits 9:5. `crcSeed` is FFFFh when control bit 12 is set and 0000h otherwise.
- R11: Control bits 31:13, 11 and 10 and status bits 31:4 read as zero. Writing all ones to address 0 reads back 0000_13FFh.
- R12: `linkUp` passes through a two-flop synchronizer. No change is reported until the synchronizer and the previous-value flop have filled after reset, so a link that is already up when reset is released does not set status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-up reset, active low, asynchronous |
| sysRstN | input | 1 | Hardware/software reset, active low, asynchronous |
| linkUp | input | 1 | Link status, asynchronous to clk |
| frameHit | input | 1 | One-cycle pulse: matched wake-up frame |
| magicHit | input | 1 | One-cycle pulse: magic packet received |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| lscFlag | output | 1 | Link-status-changed flag |
| pmeOut | output | 1 | Power-management event |
| patEnable | output | 5 | Per-pattern match enables |
| crcSeed | output | 16 | CRC-16 start value for the matcher |

## Verification
The event path is driven from a table. Each row pairs one control setting with one stimulus: a frame pulse, a magic pulse, a rising link or a falling link. Rows that differ only in one enable separate "source recorded" from "event raised", and show that an enable for one source does not open another source's path. Both link directions are tried with the matching detect bit and with the opposite one. The link-to-event path is tried with and without a direction enabled. Directed tests then cover clear-versus-set collisions, the two reset domains, reserved bits and a link that is already up at reset release.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int DATA_W  = 32;
  localparam int PAT_N   = 5;
  localparam int CRC_W   = 16;
  localparam int SYNC_N  = 2;

  // control word bit positions
  localparam int C_OFF   = 0;
  localparam int C_ON    = 1;
  localparam int C_FRM   = 2;
  localparam int C_MAG   = 3;
  localparam int C_LNK   = 4;
  localparam int C_PAT   = 5;
  localparam int C_CRC   = C_PAT + PAT_N + 2;

  // status word bit positions
  localparam int S_FRM   = 0;
  localparam int S_MAG   = 1;
  localparam int S_LSC   = 2;
  localparam int S_PME   = 3;

  typedef struct packed {
    logic             crcOnes;
    logic [PAT_N-1:0] patEn;
    logic             linkWakeEn;
    logic             magicEn;
    logic             frameEn;
    logic             onEn;
    logic             offEn;
  } ctrl_t;

  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic linkRise;
    logic linkFall;
  } strobe_t;
endpackage

// File: rtl/wake_link_sync.sv
module wake_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkIn,
  output logic rise,
  output logic fall
);
  localparam int FILL = STAGES + 1;
  localparam int CW   = $clog2(FILL + 1);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;
  logic [CW-1:0]     fillCnt;
  logic              primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevQ   <= 1'b0;
      fillCnt <= '0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], linkIn};
      prevQ <= syncQ[STAGES-1];
      if (fillCnt != CW'(FILL)) fillCnt <= fillCnt + 1'b1;
    end
  end

  assign primed = (fillCnt == CW'(FILL));
  assign rise   = primed &  syncQ[STAGES-1] & ~prevQ;
  assign fall   = primed & ~syncQ[STAGES-1] &  prevQ;

  // R12: one direction at a time, never both
  p_edge_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rise, fall}));
  // R12: nothing reported before the pipeline has filled
  p_quiet_fill_r12: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> !(rise || fall));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic    clk,
  input  logic    anyRstN,
  input  logic    linkUp,
  input  logic    regWrEn,
  input  logic    regAddr,
  output strobe_t strb
);
  logic rise, fall;

  wake_link_sync #(.STAGES(SYNC_N)) sync_i (
    .clk   (clk),
    .rstN  (anyRstN),
    .linkIn(linkUp),
    .rise  (rise),
    .fall  (fall)
  );

  always_comb begin
    strb.wrCtrl   = regWrEn & ~regAddr;
    strb.wrStat   = regWrEn &  regAddr;
    strb.linkRise = rise;
    strb.linkFall = fall;
  end
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              anyRstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              regAddr,
  input  logic              frameHit,
  input  logic              magicHit,
  output logic [DATA_W-1:0] rdData,
  output logic              lscFlag,
  output logic              pmeOut,
  output logic [PAT_N-1:0]  patEnable,
  output logic [CRC_W-1:0]  crcSeed
);
  ctrl_t ctrlQ;
  logic  frameSeen, magicSeen, lscQ, pmeQ;
  logic  clrFrm, clrMag, clrLsc, clrPme;
  logic  linkEvt, pmeSet;

  assign clrFrm  = strb.wrStat & wrData[S_FRM];
  assign clrMag  = strb.wrStat & wrData[S_MAG];
  assign clrLsc  = strb.wrStat & wrData[S_LSC];
  assign clrPme  = strb.wrStat & wrData[S_PME];

  assign linkEvt = (strb.linkRise & ctrlQ.onEn) | (strb.linkFall & ctrlQ.offEn);
  assign pmeSet  = (frameHit & ctrlQ.frameEn) | (magicHit & ctrlQ.magicEn)
                 | (linkEvt & ctrlQ.linkWakeEn);

  // control word and link flag: cleared by either reset
  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      ctrlQ <= '0;
      lscQ  <= 1'b0;
    end else begin
      if (strb.wrCtrl) begin
        ctrlQ.offEn      <= wrData[C_OFF];
        ctrlQ.onEn       <= wrData[C_ON];
        ctrlQ.frameEn    <= wrData[C_FRM];
        ctrlQ.magicEn    <= wrData[C_MAG];
        ctrlQ.linkWakeEn <= wrData[C_LNK];
        ctrlQ.patEn      <= wrData[C_PAT +: PAT_N];
        ctrlQ.crcOnes    <= wrData[C_CRC];
      end
      lscQ <= (lscQ & ~clrLsc) | linkEvt;
    end
  end

  // wake-up status: power-up reset only; set beats clear
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      frameSeen <= 1'b0;
      magicSeen <= 1'b0;
      pmeQ      <= 1'b0;
    end else begin
      frameSeen <= (frameSeen & ~clrFrm) | frameHit;
      magicSeen <= (magicSeen & ~clrMag) | magicHit;
      pmeQ      <= (pmeQ & ~clrPme) | pmeSet;
    end
  end

  always_comb begin
    rdData = '0;
    if (!regAddr) begin
      rdData[C_OFF]           = ctrlQ.offEn;
      rdData[C_ON]            = ctrlQ.onEn;
      rdData[C_FRM]           = ctrlQ.frameEn;
      rdData[C_MAG]           = ctrlQ.magicEn;
      rdData[C_LNK]           = ctrlQ.linkWakeEn;
      rdData[C_PAT +: PAT_N]  = ctrlQ.patEn;
      rdData[C_CRC]           = ctrlQ.crcOnes;
    end else begin
      rdData[S_FRM] = frameSeen;
      rdData[S_MAG] = magicSeen;
      rdData[S_LSC] = lscQ;
      rdData[S_PME] = pmeQ;
    end
  end

  assign lscFlag   = lscQ;
  assign pmeOut    = pmeQ;
  assign patEnable = ctrlQ.patEn;
  assign crcSeed   = {CRC_W{ctrlQ.crcOnes}};

  p_rise_sets_lsc_r1: assert property (@(posedge clk) disable iff (!anyRstN)
    (strb.linkRise && ctrlQ.onEn) |=> lscQ);
  p_fall_sets_lsc_r2: assert property (@(posedge clk) disable iff (!anyRstN)
    (strb.linkFall && ctrlQ.offEn) |=> lscQ);
  p_frame_pme_r3: assert property (@(posedge clk) disable iff (!porRstN)
    (frameHit && ctrlQ.frameEn) |=> pmeQ);
  p_magic_pme_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (magicHit && ctrlQ.magicEn) |=> pmeQ);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (frameHit && strb.wrStat && wrData[S_FRM]) |=> frameSeen);
  p_pme_hold_r9: assert property (@(posedge clk) disable iff (!porRstN)
    (pmeQ && !(strb.wrStat && wrData[S_PME])) |=> pmeQ);
endmodule

// File: rtl/wake_evt_top.sv
module wake_evt_top
  import wake_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              linkUp,
  input  logic              frameHit,
  input  logic              magicHit,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              lscFlag,
  output logic              pmeOut,
  output logic [PAT_N-1:0]  patEnable,
  output logic [CRC_W-1:0]  crcSeed
);
  logic    anyRstN;
  strobe_t strb;

  assign anyRstN = porRstN & sysRstN;

  wake_ctrl ctrl_i (
    .clk    (clk),
    .anyRstN(anyRstN),
    .linkUp (linkUp),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strb   (strb)
  );

  wake_datapath dp_i (
    .clk      (clk),
    .porRstN  (porRstN),
    .anyRstN  (anyRstN),
    .strb     (strb),
    .wrData   (regWrData),
    .regAddr  (regAddr),
    .frameHit (frameHit),
    .magicHit (magicHit),
    .rdData   (regRdData),
    .lscFlag  (lscFlag),
    .pmeOut   (pmeOut),
    .patEnable(patEnable),
    .crcSeed  (crcSeed)
  );
endmodule

// File: tb/wake_evt_top_tb_top.sv
module wake_evt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {req[3:0], ctrl[15:0], kind[3:0], expStatus[3:0]}
  // kind: 1 frame, 2 magic, 3 link rise, 4 link fall
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd3, 16'h0004, 4'd1, 4'h9},  // R3 frame with enable
    {4'd3, 16'h0000, 4'd1, 4'h1},  // R3 frame without enable
    {4'd4, 16'h0008, 4'd2, 4'hA},  // R4 magic with enable
    {4'd4, 16'h0000, 4'd2, 4'h2},  // R4 magic without enable
    {4'd1, 16'h0002, 4'd3, 4'h4},  // R1 rise, up-detect on
    {4'd1, 16'h0001, 4'd3, 4'h0},  // R1 rise, only down-detect on
    {4'd2, 16'h0001, 4'd4, 4'h4},  // R2 fall, down-detect on
    {4'd2, 16'h0002, 4'd4, 4'h0},  // R2 fall, only up-detect on
    {4'd5, 16'h0012, 4'd3, 4'hC},  // R5 rise raises event
    {4'd5, 16'h0011, 4'd4, 4'hC},  // R5 fall raises event
    {4'd5, 16'h0010, 4'd3, 4'h0},  // R5 no direction enabled
    {4'd4, 16'h0004, 4'd2, 4'h2}   // R4 frame enable does not cover magic
  };

  logic        clk = 0, porRstN = 0, sysRstN = 1, linkUp = 0;
  logic        frameHit = 0, magicHit = 0, regWrEn = 0, regAddr = 0;
  logic [31:0] regWrData = '0, regRdData;
  logic        lscFlag, pmeOut;
  logic [4:0]  patEnable;
  logic [15:0] crcSeed;
  int          errors = 0, checks = 0;
  logic        done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_evt_top dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0; regWrData = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic pulse(input int kind);
    @(negedge clk);
    if (kind == 1) frameHit = 1;
    if (kind == 2) magicHit = 1;
    @(negedge clk); frameHit = 0; magicHit = 0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    waitN(3);
    porRstN = 1;
    waitN(2);
    // reset state (R7)
    rd(0, d); check("R7 ctrl after reset", d, 0);
    rd(1, d); check("R7 status after reset", d, 0);
    check("R7 outputs after reset", {pmeOut, lscFlag, patEnable, crcSeed}, 0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] req, kind, expS;
      logic [15:0] cv;
      {req, cv, kind, expS} = VEC[i];
      wr(0, {16'h0, cv});
      if (kind == 3) linkUp = 0;
      if (kind == 4) linkUp = 1;
      waitN(5);
      wr(1, 32'hF);
      if (kind == 3) begin @(negedge clk); linkUp = 1; waitN(5); end
      else if (kind == 4) begin @(negedge clk); linkUp = 0; waitN(5); end
      else pulse(int'(kind));
      rd(1, d);
      check($sformatf("R%0d table row %0d", req, i), d, {28'h0, expS});
    end
    wr(1, 32'hF);

    // R11 reserved bits, R10 outputs
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R11 ctrl readback", d, 32'h0000_13FF);
    check("R10 pattern enables all", {27'h0, patEnable}, 32'h1F);
    check("R10 seed ones", {16'h0, crcSeed}, 32'hFFFF);
    wr(0, 32'h0000_00A0);
    check("R10 pattern enables sparse", {27'h0, patEnable}, 32'h05);
    check("R10 seed zero", {16'h0, crcSeed}, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); check("R11 status reserved", d, 0);

    // R6 write-one-to-clear selectivity
    wr(0, 0);
    pulse(1); pulse(2);
    wr(1, 32'h2);
    rd(1, d); check("R6 zero keeps bit", d, 32'h1);
    wr(1, 32'h1);
    rd(1, d); check("R6 one clears bit", d, 32'h0);

    // R8 set beats clear
    @(negedge clk); frameHit = 1; regWrEn = 1; regAddr = 1; regWrData = 32'h1;
    @(negedge clk); frameHit = 0; regWrEn = 0; regWrData = 0;
    rd(1, d); check("R8 set wins", d, 32'h1);
    wr(1, 32'hF);

    // R9 event holds until cleared
    wr(0, 32'h4);
    pulse(1);
    waitN(20);
    check("R9 pme held", {31'h0, pmeOut}, 1);
    wr(1, 32'h1);
    check("R9 pme held after other clear", {31'h0, pmeOut}, 1);
    wr(1, 32'h8);
    check("R9 pme cleared", {31'h0, pmeOut}, 0);

    // R7 reset domains
    wr(0, 32'h0000_0016);   // frame event, up-detect, link wake
    linkUp = 0; waitN(5);
    pulse(1);
    @(negedge clk); linkUp = 1; waitN(5);
    rd(1, d); check("R7 pre-reset status", d, 32'hD);
    @(negedge clk); sysRstN = 0;
    @(negedge clk); sysRstN = 1;
    rd(1, d); check("R7 sys reset keeps wake bits", d, 32'h9);
    rd(0, d); check("R7 sys reset clears ctrl", d, 0);
    @(negedge clk); porRstN = 0;
    @(negedge clk); porRstN = 1;
    rd(1, d); check("R7 power-up reset clears status", d, 0);

    // R12 link already up at reset release: no report
    linkUp = 1;
    @(negedge clk); porRstN = 0;
    @(negedge clk); porRstN = 1;
    regWrEn = 1; regAddr = 0; regWrData = 32'h2;
    @(negedge clk); regWrEn = 0; regWrData = 0;
    waitN(6);
    check("R12 no report on fill", {31'h0, lscFlag}, 0);
    @(negedge clk); linkUp = 0; waitN(3);
    @(negedge clk); linkUp = 1; waitN(5);
    check("R12 later rise seen", {31'h0, lscFlag}, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule